// File: doc/BRIEF.md
# Free-running 64-bit timebase with snapshot and clear commands

The block keeps a 64-bit counter that advances by one on every clock cycle and wraps to zero after its all-ones value. Software never reads the counter directly. Instead it writes a command into a control register. The latch command copies the current counter value into a pair of 32-bit holding registers, one for the low word and one for the high word. Software can then read both halves at leisure without seeing a torn value.

A second command zeroes the two holding registers. Both command bits clear themselves in the same write that acts on them. When one write carries both commands, the snapshot is taken first and the clear is applied after it, so the holding registers end at zero. Software may also write either holding register directly.

The register port is a single-cycle write strobe with a 2-bit word address and a combinational read path. The counter's starting value after reset is a parameter. Its default is zero.

Top module: `timebase64`

## Requirements
- R1: After reset, the low word (address 0), the high word (address 1) and the control register (address 2) all read as zero.
- R2: The counter holds the parameter RESET_COUNT during reset and increases by exactly one on every clock edge after reset is released. It wraps from all-ones to zero.
- R3: A write to control with bit 1 (latch) set and bit 0 clear loads the holding registers with the counter value present at the edge that accepts the write: bits 31:0 go to the low word and bits 63:32 go to the high word.
- R4: A write to control with bit 0 (clear) set and bit 1 clear sets both holding registers to zero.
- R5: A control write with both bit 0 and bit 1 set leaves both holding registers at zero.
- R6: Control bits 1:0 always read as zero. Control bits 31:2 read back the value last written to them.
- R7: A write to address 0 loads only the low word, and a write to address 1 loads only the high word. Neither write changes the other word or the control register.
- R8: When the low 32 bits of the counter wrap, the high 32 bits advance by one in the same cycle. A snapshot taken after the wrap shows the incremented high word.
- R9: Address 3 reads as zero. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 2 | Word address: 0 low, 1 high, 2 control, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
The bench takes snapshots at exact cycle numbers after reset and compares them with the reset value plus the elapsed edge count. A design that captured the value one cycle early or late fails this comparison by one. Two instances start just below a low-word wrap and just below a full 64-bit wrap. A design with a broken carry shows a stale high word after the wrap, or a nonzero word after the full rollover. Combined latch-and-clear writes and readback of the command bits catch a design that orders the two commands the wrong way or keeps the command bits stored. Writes to the unused address and to one word at a time catch address decodes that spill into neighbouring registers.

// File: rtl/timebase64_pkg.sv
package timebase64_pkg;
    typedef enum logic [1:0] {
        ADDR_LO   = 2'd0,
        ADDR_HI   = 2'd1,
        ADDR_CTL  = 2'd2,
        ADDR_NONE = 2'd3
    } tb_addr_e;

    localparam int CMD_CLEAR_BIT = 0;
    localparam int CMD_LATCH_BIT = 1;
endpackage

// File: rtl/timebase64_counter.sv
module timebase64_counter #(
    parameter int              CNT_W       = 64,
    parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RESET_COUNT;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/timebase64_regs.sv
module timebase64_regs
    import timebase64_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] ctl_o
);
    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] ctl;
    } regs_t;

    regs_t    regs_d, regs_q;
    tb_addr_e addr_w;

    assign addr_w = tb_addr_e'(addr_i);

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (addr_w)
                ADDR_LO:  regs_d.lo = wdata_i;
                ADDR_HI:  regs_d.hi = wdata_i;
                ADDR_CTL: begin
                    regs_d.ctl                = wdata_i;
                    regs_d.ctl[CMD_CLEAR_BIT] = 1'b0;
                    regs_d.ctl[CMD_LATCH_BIT] = 1'b0;
                    // snapshot first, clear second
                    if (wdata_i[CMD_LATCH_BIT]) begin
                        regs_d.lo = count_i[WORD_W-1:0];
                        regs_d.hi = count_i[CNT_W-1:WORD_W];
                    end
                    if (wdata_i[CMD_CLEAR_BIT]) begin
                        regs_d.lo = '0;
                        regs_d.hi = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr_w)
            ADDR_LO:  rdata_o = regs_q.lo;
            ADDR_HI:  rdata_o = regs_q.hi;
            ADDR_CTL: rdata_o = regs_q.ctl;
            default:  rdata_o = '0;
        endcase
    end

    assign lo_o  = regs_q.lo;
    assign hi_o  = regs_q.hi;
    assign ctl_o = regs_q.ctl;
endmodule

// File: rtl/timebase64.sv
module timebase64 #(
    parameter int                  WORD_W      = 32,
    parameter logic [2*WORD_W-1:0] RESET_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0]  count_w;
    logic [WORD_W-1:0] lo_w, hi_w, ctl_w;

    timebase64_counter #(
        .CNT_W      (CNT_W),
        .RESET_COUNT(RESET_COUNT)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .count_o(count_w)
    );

    timebase64_regs #(
        .WORD_W(WORD_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .addr_i (reg_addr),
        .wdata_i(reg_wdata),
        .count_i(count_w),
        .rdata_o(reg_rdata),
        .lo_o   (lo_w),
        .hi_o   (hi_w),
        .ctl_o  (ctl_w)
    );
endmodule

// File: rtl/timebase64_chk.sv
module timebase64_chk #(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [CNT_W-1:0]  count_q,
    input logic [WORD_W-1:0] lo_q,
    input logic [WORD_W-1:0] hi_q,
    input logic [WORD_W-1:0] ctl_q
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        count_q == $past(count_q) + CNT_W'(1)); // R2

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[1] && !reg_wdata[0])
        |=> ({hi_q, lo_q} == $past(count_q))); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[0])
        |=> (lo_q == '0 && hi_q == '0)); // R4

    AST_CMD_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[1:0] == 2'b00); // R6

    AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0)
        |=> (lo_q == $past(reg_wdata) && $stable(hi_q) && $stable(ctl_q))); // R7

    AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1)
        |=> (hi_q == $past(reg_wdata) && $stable(lo_q) && $stable(ctl_q))); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr == 2'd3)
        |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q))); // R9
endmodule

bind timebase64 timebase64_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .count_q  (count_w),
    .lo_q     (lo_w),
    .hi_q     (hi_w),
    .ctl_q    (ctl_w)
);

// File: tb/timebase64_tb.sv
module timebase64_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] INIT_A     = 64'h0000_0001_FFFF_FFF0;
    localparam logic [63:0] INIT_B     = 64'hFFFF_FFFF_FFFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [63:0] cyc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // edges seen since reset release
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 64'd1;
    end

    timebase64 #(.WORD_W(32), .RESET_COUNT(INIT_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_a));

    timebase64 #(.WORD_W(32), .RESET_COUNT(INIT_B)) u_dut_wrap (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_b));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called and returns at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic [63:0] snap);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; snap = cyc;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] va, output logic [31:0] vb);
        reg_addr = a;
        #1;
        va = rdata_a; vb = rdata_b;
    endtask

    task automatic rd64(output logic [63:0] a64, output logic [63:0] b64);
        logic [31:0] la, lb, ha, hb;
        rd(2'd0, la, lb);
        rd(2'd1, ha, hb);
        a64 = {ha, la}; b64 = {hb, lb};
    endtask

    task automatic t_reset;
        logic [31:0] va, vb;
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], va, vb);
            chk("R1 reset value", {va, vb}, 64'd0);
        end
    endtask

    task automatic t_carry;
        logic [63:0] s, a64, b64;
        while (cyc != 64'd10) @(negedge clk);
        wr(2'd2, 32'h2, s);
        rd64(a64, b64);
        chk("R8 before low wrap", a64, 64'h0000_0001_FFFF_FFFA);
        chk("R2 near full wrap", b64, 64'hFFFF_FFFF_FFFF_FFFF + 64'd3);
        while (cyc != 64'd20) @(negedge clk);
        wr(2'd2, 32'h2, s);
        rd64(a64, b64);
        chk("R8 high word after low wrap", a64, 64'h0000_0002_0000_0004);
        chk("R2 after 64-bit wrap", b64, 64'd12);
    endtask

    task automatic t_latch_points;
        logic [63:0] s1, s2, a64, b64;
        wr(2'd2, 32'h2, s1);
        rd64(a64, b64);
        chk("R3 latch A", a64, INIT_A + s1);
        chk("R3 latch B", b64, INIT_B + s1);
        repeat (7) @(negedge clk);
        wr(2'd2, 32'h2, s2);
        rd64(a64, b64);
        chk("R3 second latch", a64, INIT_A + s2);
        chk("R2 edges between latches", s2 - s1, 64'd8);
    endtask

    task automatic t_direct;
        logic [63:0] s;
        logic [31:0] va, vb;
        wr(2'd0, 32'hA5A5_0001, s);
        wr(2'd1, 32'h5A5A_0002, s);
        wr(2'd2, 32'h0000_0F00, s);
        wr(2'd0, 32'h1234_5678, s);
        rd(2'd0, va, vb); chk("R7 low write", {32'd0, va}, 64'h1234_5678);
        rd(2'd1, va, vb); chk("R7 high untouched", {32'd0, va}, 64'h5A5A_0002);
        wr(2'd1, 32'h8765_4321, s);
        rd(2'd0, va, vb); chk("R7 low untouched", {32'd0, va}, 64'h1234_5678);
        rd(2'd1, va, vb); chk("R7 high write", {32'd0, va}, 64'h8765_4321);
        rd(2'd2, va, vb); chk("R7 ctl untouched", {32'd0, va}, 64'h0000_0F00);
    endtask

    task automatic t_clear;
        logic [63:0] s, a64, b64;
        wr(2'd0, 32'hFFFF_FFFF, s);
        wr(2'd1, 32'hFFFF_FFFF, s);
        wr(2'd2, 32'h1, s);
        rd64(a64, b64);
        chk("R4 clear", a64, 64'd0);
        chk("R4 clear wrap inst", b64, 64'd0);
    endtask

    task automatic t_both;
        logic [63:0] s, a64, b64;
        wr(2'd0, 32'h0000_00AA, s);
        wr(2'd2, 32'h3, s);
        rd64(a64, b64);
        chk("R5 latch then clear", a64, 64'd0);
        chk("R5 latch then clear wrap inst", b64, 64'd0);
    endtask

    task automatic t_ctl;
        logic [63:0] s;
        logic [31:0] va, vb;
        wr(2'd2, 32'hC0DE_F0F3, s);
        rd(2'd2, va, vb); chk("R6 cmd bits zero", {32'd0, va}, 64'hC0DE_F0F0);
        wr(2'd2, 32'h0000_0002, s);
        rd(2'd2, va, vb); chk("R6 latch-only readback", {32'd0, va}, 64'd0);
    endtask

    task automatic t_unused;
        logic [63:0] s, a64, b64;
        logic [31:0] va, vb;
        wr(2'd0, 32'h1111_2222, s);
        wr(2'd1, 32'h3333_4444, s);
        wr(2'd2, 32'h0000_0100, s);
        wr(2'd3, 32'hFFFF_FFFF, s);
        rd(2'd3, va, vb); chk("R9 unused reads zero", {va, vb}, 64'd0);
        rd64(a64, b64);   chk("R9 words unchanged", a64, 64'h3333_4444_1111_2222);
        rd(2'd2, va, vb); chk("R9 ctl unchanged", {32'd0, va}, 64'h0000_0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_carry;
        t_latch_points;
        t_direct;
        t_clear;
        t_both;
        t_ctl;
        t_unused;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule